// File: doc/BRIEF.md
# Debug Trigger and Breakpoint Controller

This block makes the trigger and breakpoint decisions of an on-chip debug unit. A small state sequencer is armed by software, stepped forward by comparator-channel hits, and reaches a final state where the debug session ends. The final state can also be forced at once by a software-written immediate trigger, and the session can be cut short by an external tag-hit pin. When trace capture is running with begin or mid alignment, the breakpoint is held back until the trace buffer reports that capture is complete; otherwise it is raised at once.

Each breakpoint is routed either to a background-debug monitor request or to a software-interrupt request. The route depends on a breakpoint enable, a route-to-monitor select, and whether the monitor is enabled and already active. All request outputs are registered single-cycle pulses that appear one clock after the decision.

Top module: `dbg_trig_ctrl`

## Requirements
- R1: After reset the sequencer state is 0, no trace-end pulse and no request pulse is driven, and nothing is pending.
- R2: While armed, state 0 steps to state 1 on the next clock; each cycle with an enabled comparator hit (or a comparator tag hit) advances the state by one; a hit in state SEQ_STATES-2 enters the final state SEQ_STATES-1. While disarmed the state returns to 0 and comparator hits are ignored.
- R3: An immediate trigger moves the sequencer to the final state on the next clock, also while disarmed, and can raise a breakpoint while disarmed.
- R4: Alignment code 2'b00 is end, 2'b01 begin, 2'b10 mid, 2'b11 acts as end. With tracing off or with end alignment, the breakpoint pulse appears in the same cycle the final state is shown, a trace-end pulse accompanies it when tracing is on, and the state is 0 one cycle later.
- R5: With tracing on and begin or mid alignment, the final state is held with no request until the trace-complete input is seen; the request and trace-end pulses then appear on the next clock together with state 0.
- R6: While a breakpoint is pending, further immediate triggers and comparator hits change nothing: the state stays final and no extra request is raised; the single request still follows trace completion.
- R7: An external tag hit while armed, or while a breakpoint is pending, ends the session on the next clock whatever the alignment: state 0, a request pulse, and a trace-end pulse when tracing is on. A comparator tag hit in the same cycle does not change this.
- R8: Disarming clears a pending breakpoint that came from a comparator (state 0, no request later), but not one that came from the immediate trigger.
- R9: While the monitor is active, no request of either kind is raised.
- R10: With the breakpoint enable at 0, no request of either kind is raised.
- R11: An enabled breakpoint goes to the monitor request only when route-to-monitor is 1 and the monitor is enabled; otherwise it goes to the software-interrupt request. The two requests are never raised together.
- R12: When a monitor request coincides with a user software-interrupt instruction, a hold pulse is raised with it so the monitor request is served first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| arm_i | input | 1 | Unit armed |
| cmp_hit_i | input | NUM_CH | Comparator channel hits |
| cmp_tag_i | input | 1 | Comparator tag hit |
| ext_tag_i | input | 1 | External tag-hit pin |
| imm_trig_i | input | 1 | Immediate trigger write pulse |
| trace_en_i | input | 1 | Trace capture enabled |
| align_i | input | 2 | Trace alignment code |
| trace_done_i | input | 1 | Trace capture complete pulse |
| brk_en_i | input | 1 | Breakpoint enable |
| brk_to_mon_i | input | 1 | Route breakpoints to the monitor |
| mon_en_i | input | 1 | Monitor enabled |
| mon_active_i | input | 1 | Monitor currently active |
| swi_insn_i | input | 1 | User software-interrupt instruction in this cycle |
| seq_state_o | output | SW | Sequencer state |
| trace_end_o | output | 1 | Trace session end pulse |
| brk_mon_o | output | 1 | Monitor breakpoint request pulse |
| brk_swi_o | output | 1 | Software-interrupt breakpoint request pulse |
| user_swi_hold_o | output | 1 | Hold of the user software interrupt behind a monitor request |

## Verification
Routing is tried with every meaningful mix of enable, route select, monitor enable, monitor activity and a coinciding user software interrupt, which separates the monitor path, the software-interrupt fallback and the two suppressions. The sequencer is tried with comparator stepping under end, begin and mid alignment, which tells immediate from deferred requests, and with late immediate triggers and comparator hits during a pending wait, which tells ignored triggers from doubled requests. Disarming during a comparator-started and an immediate-started wait separates the two cancellation rules, and external tag hits during a wait and together with a comparator tag show that the session ends at once.

// File: rtl/dbg_trig_pkg.sv
package dbg_trig_pkg;

    typedef enum logic [1:0] {
        ALIGN_END   = 2'b00,
        ALIGN_BEGIN = 2'b01,
        ALIGN_MID   = 2'b10,
        ALIGN_RSVD  = 2'b11
    } align_e;

    typedef enum logic [1:0] {
        RT_NONE = 2'b00,
        RT_SWI  = 2'b01,
        RT_MON  = 2'b10
    } route_e;

    // Begin and mid alignment keep capturing after the trigger.
    function automatic logic align_defers(input logic [1:0] code);
        return (code == ALIGN_BEGIN) || (code == ALIGN_MID);
    endfunction

endpackage

// File: rtl/dbg_trig_src.sv
module dbg_trig_src #(
    parameter int NUM_CH = 4,
    parameter logic [NUM_CH-1:0] CH_MASK = '1
) (
    input  logic              arm_i,
    input  logic [NUM_CH-1:0] cmp_hit_i,
    input  logic              cmp_tag_i,
    output logic              adv_o
);

    logic [NUM_CH-1:0] gated;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        if (CH_MASK[c]) begin : g_on
            assign gated[c] = cmp_hit_i[c];
        end else begin : g_off
            assign gated[c] = 1'b0;
        end
    end

    assign adv_o = arm_i && ((|gated) || cmp_tag_i);

endmodule

// File: rtl/dbg_trig_seq.sv
module dbg_trig_seq
    import dbg_trig_pkg::*;
#(
    parameter int SEQ_STATES = 4,
    parameter int SW = 2
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          arm_i,
    input  logic          adv_i,
    input  logic          ext_tag_i,
    input  logic          imm_trig_i,
    input  logic          trace_en_i,
    input  logic [1:0]    align_i,
    input  logic          trace_done_i,
    output logic [SW-1:0] state_o,
    output logic          pend_o,
    output logic          fire_o,
    output logic          trace_end_o
);

    localparam logic [SW-1:0] FINAL     = SW'(SEQ_STATES - 1);
    localparam logic [SW-1:0] PRE_FINAL = SW'(SEQ_STATES - 2);
    localparam logic [SW-1:0] FIRST     = SW'(1);

    typedef struct packed {
        logic [SW-1:0] st;
        logic          pend;
        logic          pend_imm;
        logic          end_p;
    } seq_t;

    seq_t seq_d, seq_q;
    logic fire_d;
    logic defer;

    always_comb begin
        seq_d       = seq_q;
        seq_d.end_p = 1'b0;
        fire_d      = 1'b0;
        defer       = trace_en_i && align_defers(align_i);

        if (ext_tag_i && (arm_i || seq_q.pend)) begin
            // tag pin: always end-aligned, ends the session now
            seq_d.st       = '0;
            seq_d.pend     = 1'b0;
            seq_d.pend_imm = 1'b0;
            seq_d.end_p    = trace_en_i;
            fire_d         = 1'b1;
        end else if (seq_q.pend) begin
            if (trace_done_i) begin
                seq_d.st       = '0;
                seq_d.pend     = 1'b0;
                seq_d.pend_imm = 1'b0;
                seq_d.end_p    = 1'b1;
                fire_d         = 1'b1;
            end else if (!arm_i && !seq_q.pend_imm) begin
                seq_d.st   = '0;
                seq_d.pend = 1'b0;
            end
        end else if (seq_q.st == FINAL) begin
            seq_d.st = '0;
        end else if (imm_trig_i) begin
            seq_d.st = FINAL;
            if (defer) begin
                seq_d.pend     = 1'b1;
                seq_d.pend_imm = 1'b1;
            end else begin
                seq_d.end_p = trace_en_i;
                fire_d      = 1'b1;
            end
        end else if (!arm_i) begin
            seq_d.st = '0;
        end else if (seq_q.st == '0) begin
            seq_d.st = FIRST;
        end else if (adv_i) begin
            if (seq_q.st == PRE_FINAL) begin
                seq_d.st = FINAL;
                if (defer) begin
                    seq_d.pend     = 1'b1;
                    seq_d.pend_imm = 1'b0;
                end else begin
                    seq_d.end_p = trace_en_i;
                    fire_d      = 1'b1;
                end
            end else begin
                seq_d.st = seq_q.st + FIRST;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign state_o     = seq_q.st;
    assign pend_o      = seq_q.pend;
    assign fire_o      = fire_d;
    assign trace_end_o = seq_q.end_p;

endmodule

// File: rtl/dbg_brk_route.sv
module dbg_brk_route
    import dbg_trig_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic fire_i,
    input  logic brk_en_i,
    input  logic brk_to_mon_i,
    input  logic mon_en_i,
    input  logic mon_active_i,
    input  logic swi_insn_i,
    output logic brk_mon_o,
    output logic brk_swi_o,
    output logic hold_o
);

    typedef struct packed {
        logic mon;
        logic swi;
        logic hold;
    } req_t;

    req_t   req_d, req_q;
    route_e route;

    always_comb begin
        route = RT_NONE;
        if (fire_i && brk_en_i && !mon_active_i) begin
            route = (brk_to_mon_i && mon_en_i) ? RT_MON : RT_SWI;
        end
        req_d.mon  = (route == RT_MON);
        req_d.swi  = (route == RT_SWI);
        req_d.hold = (route == RT_MON) && swi_insn_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            req_q <= '0;
        end else begin
            req_q <= req_d;
        end
    end

    assign brk_mon_o = req_q.mon;
    assign brk_swi_o = req_q.swi;
    assign hold_o    = req_q.hold;

endmodule

// File: rtl/dbg_trig_ctrl.sv
module dbg_trig_ctrl #(
    parameter int NUM_CH = 4,
    parameter logic [NUM_CH-1:0] CH_MASK = '1,
    parameter int SEQ_STATES = 4,
    localparam int SW = (SEQ_STATES > 2) ? $clog2(SEQ_STATES) : 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              arm_i,
    input  logic [NUM_CH-1:0] cmp_hit_i,
    input  logic              cmp_tag_i,
    input  logic              ext_tag_i,
    input  logic              imm_trig_i,
    input  logic              trace_en_i,
    input  logic [1:0]        align_i,
    input  logic              trace_done_i,
    input  logic              brk_en_i,
    input  logic              brk_to_mon_i,
    input  logic              mon_en_i,
    input  logic              mon_active_i,
    input  logic              swi_insn_i,
    output logic [SW-1:0]     seq_state_o,
    output logic              trace_end_o,
    output logic              brk_mon_o,
    output logic              brk_swi_o,
    output logic              user_swi_hold_o
);

    logic adv_w;
    logic pend_w;
    logic fire_w;

    dbg_trig_src #(
        .NUM_CH (NUM_CH),
        .CH_MASK(CH_MASK)
    ) u_src (
        .arm_i    (arm_i),
        .cmp_hit_i(cmp_hit_i),
        .cmp_tag_i(cmp_tag_i),
        .adv_o    (adv_w)
    );

    dbg_trig_seq #(
        .SEQ_STATES(SEQ_STATES),
        .SW        (SW)
    ) u_seq (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .arm_i       (arm_i),
        .adv_i       (adv_w),
        .ext_tag_i   (ext_tag_i),
        .imm_trig_i  (imm_trig_i),
        .trace_en_i  (trace_en_i),
        .align_i     (align_i),
        .trace_done_i(trace_done_i),
        .state_o     (seq_state_o),
        .pend_o      (pend_w),
        .fire_o      (fire_w),
        .trace_end_o (trace_end_o)
    );

    dbg_brk_route u_route (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .fire_i      (fire_w),
        .brk_en_i    (brk_en_i),
        .brk_to_mon_i(brk_to_mon_i),
        .mon_en_i    (mon_en_i),
        .mon_active_i(mon_active_i),
        .swi_insn_i  (swi_insn_i),
        .brk_mon_o   (brk_mon_o),
        .brk_swi_o   (brk_swi_o),
        .hold_o      (user_swi_hold_o)
    );

endmodule

// File: rtl/dbg_trig_ctrl_chk.sv
module dbg_trig_ctrl_chk #(
    parameter int SEQ_STATES = 4,
    parameter int SW = 2
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic          arm_i,
    input logic          ext_tag_i,
    input logic          imm_trig_i,
    input logic          trace_en_i,
    input logic          trace_done_i,
    input logic          brk_en_i,
    input logic          brk_to_mon_i,
    input logic          mon_en_i,
    input logic          mon_active_i,
    input logic          pend_i,
    input logic [SW-1:0] seq_state_o,
    input logic          trace_end_o,
    input logic          brk_mon_o,
    input logic          brk_swi_o,
    input logic          user_swi_hold_o
);

    localparam logic [SW-1:0] FINAL = SW'(SEQ_STATES - 1);

    a_r3_imm_final: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (imm_trig_i && !pend_i && !ext_tag_i && seq_state_o != FINAL) |=> (seq_state_o == FINAL));

    a_r6_pending_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pend_i && arm_i && !trace_done_i && !ext_tag_i)
        |=> (seq_state_o == FINAL && !brk_mon_o && !brk_swi_o));

    a_r7_ext_tag_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ext_tag_i && arm_i && trace_en_i) |=> (seq_state_o == '0 && trace_end_o));

    a_r9_active_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mon_active_i |=> (!brk_mon_o && !brk_swi_o));

    a_r10_disabled_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !brk_en_i |=> (!brk_mon_o && !brk_swi_o));

    a_r11_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(brk_mon_o && brk_swi_o));

    a_r11_mon_route: assert property (@(posedge clk_i) disable iff (!rst_ni)
        brk_mon_o |-> ($past(brk_to_mon_i) && $past(mon_en_i)));

    a_r12_hold_with_mon: assert property (@(posedge clk_i) disable iff (!rst_ni)
        user_swi_hold_o |-> brk_mon_o);

endmodule

bind dbg_trig_ctrl dbg_trig_ctrl_chk #(
    .SEQ_STATES(SEQ_STATES),
    .SW        (SW)
) u_chk (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .arm_i          (arm_i),
    .ext_tag_i      (ext_tag_i),
    .imm_trig_i     (imm_trig_i),
    .trace_en_i     (trace_en_i),
    .trace_done_i   (trace_done_i),
    .brk_en_i       (brk_en_i),
    .brk_to_mon_i   (brk_to_mon_i),
    .mon_en_i       (mon_en_i),
    .mon_active_i   (mon_active_i),
    .pend_i         (pend_w),
    .seq_state_o    (seq_state_o),
    .trace_end_o    (trace_end_o),
    .brk_mon_o      (brk_mon_o),
    .brk_swi_o      (brk_swi_o),
    .user_swi_hold_o(user_swi_hold_o)
);

// File: tb/test_dbg_trig_ctrl.sv
module test_dbg_trig_ctrl;

    localparam int NUM_CH = 4;
    localparam int SW = 2;
    localparam int FINAL = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic arm = 0, cmp_tag = 0, ext_tag = 0, imm = 0, trace_en = 0, done_in = 0;
    logic [NUM_CH-1:0] cmp_hit = '0;
    logic [1:0] align = 2'b00;
    logic brk_en = 1, to_mon = 0, mon_en = 0, mon_act = 0, swi_insn = 0;
    logic [SW-1:0] state;
    logic tr_end, b_mon, b_swi, hold;

    int checks = 0;
    int fails = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    dbg_trig_ctrl i_dbg_trig_ctrl (
        .clk_i(clk), .rst_ni(rst_n), .arm_i(arm), .cmp_hit_i(cmp_hit),
        .cmp_tag_i(cmp_tag), .ext_tag_i(ext_tag), .imm_trig_i(imm),
        .trace_en_i(trace_en), .align_i(align), .trace_done_i(done_in),
        .brk_en_i(brk_en), .brk_to_mon_i(to_mon), .mon_en_i(mon_en),
        .mon_active_i(mon_act), .swi_insn_i(swi_insn),
        .seq_state_o(state), .trace_end_o(tr_end), .brk_mon_o(b_mon),
        .brk_swi_o(b_swi), .user_swi_hold_o(hold)
    );

    // {brk_en, to_mon, mon_en, active, swi_insn, exp_mon, exp_swi, exp_hold}
    localparam logic [7:0] ROUTE_VEC [9] = '{
        8'b11100_100, 8'b11101_101, 8'b10100_010, 8'b10001_010, 8'b11000_010,
        8'b11110_000, 8'b10010_000, 8'b01100_000, 8'b00001_000
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic rearm();
        arm = 0; step(); step();
        arm = 1; step();
    endtask

    task automatic hit_once();
        cmp_hit = 4'b0010; step(); cmp_hit = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        step(); step();
        rst_n = 1; step();
        chk("R1 state", int'(state), 0);
        chk("R1 no request", int'(b_mon | b_swi | tr_end | hold), 0);

        // routing table, fired by immediate trigger while disarmed, tracing off
        for (int i = 0; i < 9; i++) begin
            brk_en = ROUTE_VEC[i][7]; to_mon = ROUTE_VEC[i][6];
            mon_en = ROUTE_VEC[i][5]; mon_act = ROUTE_VEC[i][4];
            swi_insn = ROUTE_VEC[i][3];
            imm = 1; step(); imm = 0; swi_insn = 0;
            chk("R3 final after imm", int'(state), FINAL);
            chk("R9 R10 R11 mon", int'(b_mon), int'(ROUTE_VEC[i][2]));
            chk("R9 R10 R11 swi", int'(b_swi), int'(ROUTE_VEC[i][1]));
            chk("R12 hold", int'(hold), int'(ROUTE_VEC[i][0]));
            step();
            chk("R4 back to 0", int'(state), 0);
        end
        brk_en = 1; to_mon = 0; mon_en = 0; mon_act = 0;

        // R2 stepping, disarmed hits ignored
        cmp_hit = 4'b0001; step(); cmp_hit = '0;
        chk("R2 disarmed hit ignored", int'(state), 0);
        arm = 1; step();
        chk("R2 armed enters 1", int'(state), 1);
        hit_once();
        chk("R2 hit advances", int'(state), 2);
        step();
        chk("R2 no hit holds", int'(state), 2);
        hit_once();
        chk("R2 final reached", int'(state), FINAL);
        chk("R4 immediate swi no trace", int'(b_swi), 1);
        step();
        chk("R4 state 0 after final", int'(state), 0);

        // R4 end alignment with tracing
        trace_en = 1; align = 2'b00;
        rearm(); hit_once(); hit_once();
        chk("R4 end-aligned request", int'(b_swi), 1);
        chk("R4 end-aligned trace end", int'(tr_end), 1);

        // R5 begin alignment defers
        align = 2'b01;
        rearm(); hit_once(); hit_once();
        chk("R5 no request yet", int'(b_swi), 0);
        step(); step();
        chk("R5 final held", int'(state), FINAL);
        chk("R5 still no request", int'(b_swi | tr_end), 0);
        done_in = 1; step(); done_in = 0;
        chk("R5 request on done", int'(b_swi), 1);
        chk("R5 trace end on done", int'(tr_end), 1);
        chk("R5 state 0", int'(state), 0);

        // R6 mid alignment, late triggers ignored
        align = 2'b10;
        rearm(); hit_once(); hit_once();
        imm = 1; step(); imm = 0;
        chk("R6 imm ignored", int'(b_swi), 0);
        chk("R6 state final", int'(state), FINAL);
        hit_once();
        chk("R6 hit ignored", int'(b_swi), 0);
        done_in = 1; step(); done_in = 0;
        chk("R6 single request on done", int'(b_swi), 1);
        step();
        chk("R6 no second request", int'(b_swi), 0);

        // R8 disarm cancels comparator-started wait
        align = 2'b01;
        rearm(); hit_once(); hit_once();
        arm = 0; step();
        chk("R8 cancel state", int'(state), 0);
        done_in = 1; step(); done_in = 0;
        chk("R8 no request after cancel", int'(b_swi), 0);

        // R8 immediate-started wait survives disarm
        imm = 1; step(); imm = 0;
        chk("R3 disarmed imm final", int'(state), FINAL);
        step(); step();
        chk("R8 imm wait kept", int'(state), FINAL);
        done_in = 1; step(); done_in = 0;
        chk("R3 R8 disarmed request", int'(b_swi), 1);

        // R7 external tag ends pending wait
        rearm(); hit_once(); hit_once();
        chk("R7 pending first", int'(b_swi), 0);
        ext_tag = 1; step(); ext_tag = 0;
        chk("R7 tag request", int'(b_swi), 1);
        chk("R7 tag trace end", int'(tr_end), 1);
        chk("R7 tag state 0", int'(state), 0);

        // R7 simultaneous comparator tag and external tag
        rearm(); hit_once();
        ext_tag = 1; cmp_tag = 1; step(); ext_tag = 0; cmp_tag = 0;
        chk("R7 both tags state 0", int'(state), 0);
        chk("R7 both tags request", int'(b_swi), 1);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule